// File: doc/BRIEF.md
# Self-Synchronizing Lane Lock Tracker

This block watches the decoded character stream of one receive lane and decides alone whether the lane is locked. It needs no handshake and no return path to the far transmitter. Each clock brings at most one character, marked by a valid strobe and flagged if the decoder found a code or disparity fault. Lock is declared after a long unbroken run of clean characters. It is withdrawn after a short unbroken run of faulty ones. The thresholds are parameters and default to 64 and 4.

The tracker ignores the stream and holds the link down until the transceiver reports that its reset sequence is complete. Losing that indication at any time drops the link and discards any partial runs. A force-train request from outside steers the local transmitter onto training patterns. Software holds this request until the far receiver is expected to have locked, and asserts it again after a drop. A saturating counter of up-to-down transitions lets software see those drops.

Top module: `selfsync_link_fsm`

## Requirements
- R1: During and right after synchronous reset, `link_up` is 0 and `drop_count` is 0.
- R2: With `xcvr_ready` high and the link down, `link_up` goes to 1 on the clock edge that samples the 64th consecutive character with `rx_valid`=1 and `rx_err`=0. After 63 such characters it is still 0.
- R3: While the link is down, a character with `rx_valid`=1 and `rx_err`=1 discards the clean run, so a full 64 new clean characters are needed.
- R4: Cycles with `rx_valid`=0 neither advance nor clear either run, whatever `rx_err` shows.
- R5: While the link is up, `link_up` goes to 0 on the edge that samples the 4th consecutive valid errored character.
- R6: While the link is up, a clean valid character clears the error run, so errors must be back-to-back to drop the link.
- R7: While `xcvr_ready` is 0, `link_up` is 0 from the next edge on and characters are ignored. Its loss also clears both runs.
- R8: `tx_train_sel` equals `force_train` in the same cycle, in every link state (1 selects training patterns).
- R9: `drop_count` increments by one on each 1-to-0 transition of `link_up`, whether caused by errors or by loss of `xcvr_ready`, and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A character is present this cycle |
| rx_err | input | 1 | The present character has a code or disparity fault |
| xcvr_ready | input | 1 | Transceiver reset sequence complete |
| force_train | input | 1 | Request to send training patterns |
| link_up | output | 1 | Registered lock status |
| tx_train_sel | output | 1 | Transmit path selects training patterns |
| drop_count | output | 8 | Saturating count of link drops |

## Verification
The bench probes both thresholds from each side, at 63 versus 64 clean characters and 3 versus 4 errors. An off-by-one counter would raise or drop the link one character early or late. It breaks runs with one faulty character, one clean character and long stretches of invalid cycles. A design that failed to restart acquisition, left old errors in place, or counted idle cycles would then change state at the wrong point. Partial runs are interrupted by loss of transceiver readiness, which catches stale counts that survive the loss. About 260 forced drops check that the drop counter holds at its ceiling instead of wrapping to zero.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic {
        LS_DOWN = 1'b0,
        LS_UP   = 1'b1
    } link_state_e;

    typedef struct packed {
        logic valid;
        logic err;
    } rx_char_t;

    function automatic logic is_clean(input rx_char_t c);
        return c.valid && !c.err;
    endfunction

    function automatic logic is_faulty(input rx_char_t c);
        return c.valid && c.err;
    endfunction

endpackage

// File: rtl/lsm_run_counter.sv
module lsm_run_counter #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= (count == LAST) ? '0 : count + 1'b1;
    end

    assign hit = inc && !clr && (count == LAST);

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(count));

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

endmodule

// File: rtl/lsm_drop_counter.sv
module lsm_drop_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] CEIL = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (bump && count != CEIL)
            count <= count + 1'b1;
    end

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == CEIL) |-> (count == CEIL));

endmodule

// File: rtl/selfsync_link_fsm.sv
module selfsync_link_fsm
    import lsm_pkg::*;
#(
    parameter int GOOD_RUN = 64,
    parameter int BAD_RUN  = 4,
    parameter int DROP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic              xcvr_ready,
    input  logic              force_train,
    output logic              link_up,
    output logic              tx_train_sel,
    output logic [DROP_W-1:0] drop_count
);
    link_state_e state, state_nx;
    rx_char_t    ch;
    logic        good_hit, bad_hit;
    logic        good_inc, good_clr, bad_inc, bad_clr;
    logic        drop_evt;

    assign ch = '{valid: rx_valid, err: rx_err};

    always_comb begin
        good_inc = xcvr_ready && (state == LS_DOWN) && is_clean(ch);
        good_clr = !xcvr_ready || (state == LS_UP) || is_faulty(ch);
        bad_inc  = xcvr_ready && (state == LS_UP) && is_faulty(ch);
        bad_clr  = !xcvr_ready || (state == LS_DOWN) || is_clean(ch);
    end

    lsm_run_counter #(.LIMIT(GOOD_RUN)) u_good (
        .clk(clk), .rst(rst), .clr(good_clr), .inc(good_inc), .hit(good_hit)
    );

    lsm_run_counter #(.LIMIT(BAD_RUN)) u_bad (
        .clk(clk), .rst(rst), .clr(bad_clr), .inc(bad_inc), .hit(bad_hit)
    );

    always_comb begin
        state_nx = state;
        if (!xcvr_ready)
            state_nx = LS_DOWN;
        else if (state == LS_DOWN && good_hit)
            state_nx = LS_UP;
        else if (state == LS_UP && bad_hit)
            state_nx = LS_DOWN;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= LS_DOWN;
        else
            state <= state_nx;
    end

    assign drop_evt = !rst && (state == LS_UP) && (state_nx == LS_DOWN);

    lsm_drop_counter #(.WIDTH(DROP_W)) u_drops (
        .clk(clk), .rst(rst), .bump(drop_evt), .count(drop_count)
    );

    assign link_up      = (state == LS_UP);
    assign tx_train_sel = force_train;

    a_r2_rise_on_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(xcvr_ready && rx_valid && !rx_err));

    a_r5_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(link_up) |-> $past(rst || !xcvr_ready || (rx_valid && rx_err)));

    a_r7_not_ready_down: assert property (@(posedge clk) disable iff (rst)
        !xcvr_ready |=> !link_up);

    a_r9_count_only_on_drop: assert property (@(posedge clk) disable iff (rst)
        (!$fell(link_up) && !$past(rst)) |-> $stable(drop_count));

    a_r8_train_follows: assert property (@(posedge clk) disable iff (rst)
        tx_train_sel == force_train);

endmodule

// File: tb/selfsync_link_fsm_tb.sv
module selfsync_link_fsm_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic       rx_err = 1'b0;
    logic       xcvr_ready = 1'b0;
    logic       force_train = 1'b0;
    logic       link_up;
    logic       tx_train_sel;
    logic [7:0] drop_count;

    int n_chk = 0;
    int n_bad = 0;
    int exp_drops = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    selfsync_link_fsm u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_err(rx_err),
        .xcvr_ready(xcvr_ready), .force_train(force_train),
        .link_up(link_up), .tx_train_sel(tx_train_sel), .drop_count(drop_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic e, input int n);
        for (int i = 0; i < n; i++) begin
            rx_valid = v;
            rx_err   = e;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic ready_blip();
        xcvr_ready = 1'b0;
        @(negedge clk);
        xcvr_ready = 1'b1;
    endtask

    task automatic note_drop();
        if (exp_drops < 255) exp_drops++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 link_up in reset", link_up, 0);
        chk("R1 drop_count in reset", drop_count, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 link_up after reset", link_up, 0);
        chk("R1 drop_count after reset", drop_count, 0);

        force_train = 1'b1; #1;
        chk("R8 train select high", tx_train_sel, 1);
        force_train = 1'b0; #1;
        chk("R8 train select low", tx_train_sel, 0);

        step(1'b1, 1'b0, 100);
        chk("R7 ignored while not ready", link_up, 0);
        xcvr_ready = 1'b1;

        step(1'b1, 1'b0, 63);
        chk("R2 down after 63 clean", link_up, 0);
        step(1'b1, 1'b0, 1);
        chk("R2 up after 64 clean", link_up, 1);
        force_train = 1'b1; #1;
        chk("R8 train select while up", tx_train_sel, 1);
        force_train = 1'b0;

        step(1'b1, 1'b1, 3);
        chk("R5 up after 3 errors", link_up, 1);
        step(1'b1, 1'b0, 1);
        step(1'b1, 1'b1, 3);
        chk("R6 good char resets error run", link_up, 1);
        step(1'b1, 1'b1, 1);
        chk("R5 down after 4th error", link_up, 0);
        note_drop();
        chk("R9 one drop counted", drop_count, exp_drops);

        step(1'b1, 1'b0, 63);
        step(1'b1, 1'b1, 1);
        step(1'b1, 1'b0, 63);
        chk("R3 run restarted after error", link_up, 0);
        step(1'b1, 1'b0, 1);
        chk("R3 up after fresh 64", link_up, 1);

        step(1'b1, 1'b1, 4);
        note_drop();
        chk("R5 down again", link_up, 0);
        step(1'b1, 1'b0, 32);
        step(1'b0, 1'b1, 25);
        step(1'b0, 1'b0, 25);
        step(1'b1, 1'b0, 31);
        chk("R4 idle cycles do not count", link_up, 0);
        step(1'b1, 1'b0, 1);
        chk("R4 idle cycles do not clear", link_up, 1);
        step(1'b1, 1'b1, 3);
        step(1'b0, 1'b1, 20);
        chk("R4 idle does not advance errors", link_up, 1);
        step(1'b1, 1'b1, 1);
        chk("R4 idle does not clear errors", link_up, 0);
        note_drop();
        chk("R9 drops so far", drop_count, exp_drops);

        step(1'b1, 1'b0, 64);
        chk("R2 relock", link_up, 1);
        ready_blip();
        chk("R7 ready loss drops link", link_up, 0);
        note_drop();
        chk("R9 ready loss counted", drop_count, exp_drops);
        step(1'b1, 1'b0, 40);
        ready_blip();
        step(1'b1, 1'b0, 63);
        chk("R7 partial run cleared", link_up, 0);
        step(1'b1, 1'b0, 1);
        chk("R7 full run after clear", link_up, 1);
        step(1'b1, 1'b1, 3);
        ready_blip();
        note_drop();
        step(1'b1, 1'b0, 64);
        step(1'b1, 1'b1, 3);
        chk("R7 error run cleared by ready loss", link_up, 1);
        step(1'b1, 1'b0, 1);

        for (int k = 0; k < 260; k++) begin
            ready_blip();
            note_drop();
            step(1'b1, 1'b0, 64);
            if (k % 64 == 0)
                chk("R9 drop count tracking", drop_count, exp_drops);
        end
        chk("R9 saturated at 255", drop_count, 255);
        ready_blip();
        chk("R9 stays saturated", drop_count, 255);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule